// File: doc/BRIEF.md
# Dual-Mode Virtual/Physical L1 Tag Lookup

This block is the tag-lookup and hit-decision stage of a set-associative L1 data cache. It can match a line under either its virtual address or its physical address. A path selector chooses the path for each request. The choice comes from a global enable together with the top virtual address bit or, in a build variant, from a pair of inclusive bound registers.

On the physical path the set index is taken from page-offset bits only. A translation request goes out in the same cycle as the access. In the next cycle the stored tags are compared with the returned page number. On the virtual path no translation is requested, and a line matches on its virtual tag and address-space ID. The line's path bit must agree with the path of the request in both cases. A write to a virtual line without write permission is reported as a fault rather than a hit.

A flush command drops every virtually tagged line and is used when a synonym conflict is suspected. A saturating counter records how many translations the virtual path has avoided. Tag install is available through a fill port. Data storage, refill sequencing and coherence are handled elsewhere.

Top module: `ovl_l1_lookup`

## Requirements
- R1: A request takes the virtual path only when the enable register (config address 0, data bit 0) is 1 and `req_va_i[47]` is 1. Every other request takes the physical path.
- R2: After reset the enable register is 0, no line is valid, the avoided-lookup count is 0, and `resp_valid_o`, `hit_o` and `fault_o` are low.
- R3: `tlb_req_o` is high in the same cycle as a physical-path request and stays low for virtual-path requests.
- R4: The result of a request appears on `resp_valid_o`/`hit_o`/`fault_o`/`way_o` in the cycle after the request. A virtual hit requires a valid line marked virtual, a stored tag equal to `req_va_i[47:12]`, and a stored ASID equal to `req_asid_i`. The set is `req_va_i[11:6]`.
- R5: A physical hit requires `tlb_valid_i` high in the response cycle, a valid line marked physical, and a stored tag equal to the zero-extended `tlb_ppn_i`. The ASID plays no part in a physical hit.
- R6: `flush_i` invalidates every line marked virtual and leaves physical lines intact. A virtual line installed in the same cycle as a flush is not kept, while a physical line installed in that cycle is kept.
- R7: A write that matches a virtual line whose write-permission bit is 0 sets `fault_o` and clears `hit_o`. A matching write with the permission bit set is a normal hit.
- R8: A physical lookup never hits a line marked virtual, and a virtual lookup never hits a line marked physical, even when the tags are equal.
- R9: `saved_o` increments by one for each virtual-path request and holds at its all-ones maximum.
- R10: With `USE_RANGE=1`, the virtual path is taken when the enable is 1 and the full VA lies between the lower bound (config address 1) and the upper bound (config address 2), both ends inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Config register write strobe |
| cfg_addr_i | input | 2 | Config select: 0 enable, 1 lower bound, 2 upper bound |
| cfg_wdata_i | input | VA_W | Config write data |
| req_i | input | 1 | Lookup request |
| req_va_i | input | VA_W | Virtual address of request |
| req_asid_i | input | ASID_W | Address-space ID of request |
| req_wr_i | input | 1 | Request is a write |
| tlb_req_o | output | 1 | Translation request strobe |
| tlb_valid_i | input | 1 | Translation valid, response cycle |
| tlb_ppn_i | input | PA_W-12 | Translated page number, response cycle |
| fill_i | input | 1 | Install a tag entry |
| fill_set_i | input | SET_W | Set of installed entry |
| fill_way_i | input | WAY_W | Way of installed entry |
| fill_virt_i | input | 1 | Installed entry is virtually tagged |
| fill_asid_i | input | ASID_W | ASID of installed entry |
| fill_wr_ok_i | input | 1 | Installed entry permits writes |
| fill_tag_i | input | TAG_W | Tag of installed entry |
| flush_i | input | 1 | Invalidate all virtual entries |
| resp_valid_o | output | 1 | Result valid |
| hit_o | output | 1 | Lookup hit |
| fault_o | output | 1 | Write-permission fault |
| way_o | output | WAY_W | Hitting way |
| saved_o | output | CNT_W | Saturating count of avoided translations |

## Verification
The bench targets a path bit that is ignored: that design would let a physical page number hit a virtual line that has the same tag pattern, or the reverse. It targets a missing ASID compare, which would hit across address spaces, and a missing permission check, which would report a hit on a read-only line that is being written. A flush that also clears physical lines shows up as a lost physical hit right after the flush. The bench also probes the inclusive ends of the range classifier and saturation of the counter, since an off-by-one there misroutes the edge addresses or wraps to zero.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic {PATH_PHYS = 1'b0, PATH_VIRT = 1'b1} path_e;
  typedef enum logic [1:0] {CFG_EN = 2'd0, CFG_LO = 2'd1, CFG_HI = 2'd2} cfg_sel_e;
endpackage

// File: rtl/ovl_mode_sel.sv
module ovl_mode_sel
  import ovl_pkg::*;
#(
  parameter int VA_W      = 48,
  parameter bit USE_RANGE = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [1:0]      cfg_addr_i,
  input  logic [VA_W-1:0] cfg_wdata_i,
  input  logic [VA_W-1:0] va_i,
  output path_e           path_o,
  output logic            en_o
);
  logic            en_q;
  logic [VA_W-1:0] lo_q, hi_q;
  logic            in_rng, pick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      lo_q <= '0;
      hi_q <= '0;
    end else if (cfg_we_i) begin
      case (cfg_sel_e'(cfg_addr_i))
        CFG_EN:  en_q <= cfg_wdata_i[0];
        CFG_LO:  lo_q <= cfg_wdata_i;
        CFG_HI:  hi_q <= cfg_wdata_i;
        default: ;
      endcase
    end
  end

  assign in_rng = (va_i >= lo_q) && (va_i <= hi_q);
  assign pick   = USE_RANGE ? in_rng : va_i[VA_W-1];
  assign path_o = (en_q && pick) ? PATH_VIRT : PATH_PHYS;
  assign en_o   = en_q;
endmodule

// File: rtl/ovl_tag_store.sv
module ovl_tag_store #(
  parameter int SETS   = 64,
  parameter int WAYS   = 8,
  parameter int ASID_W = 16,
  parameter int TAG_W  = 36,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         fill_i,
  input  logic [SET_W-1:0]             fill_set_i,
  input  logic [WAY_W-1:0]             fill_way_i,
  input  logic                         fill_virt_i,
  input  logic [ASID_W-1:0]            fill_asid_i,
  input  logic                         fill_wr_ok_i,
  input  logic [TAG_W-1:0]             fill_tag_i,
  input  logic                         flush_i,
  input  logic [SET_W-1:0]             rd_set_i,
  output logic [WAYS-1:0]              rd_valid_o,
  output logic [WAYS-1:0]              rd_virt_o,
  output logic [WAYS-1:0]              rd_wok_o,
  output logic [WAYS-1:0][ASID_W-1:0]  rd_asid_o,
  output logic [WAYS-1:0][TAG_W-1:0]   rd_tag_o
);
  logic [WAYS-1:0]             valid_q [SETS];
  logic [WAYS-1:0]             virt_q  [SETS];
  logic [WAYS-1:0]             wok_q   [SETS];
  logic [WAYS-1:0][ASID_W-1:0] asid_q  [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];

  // fill owns its entry; a virtual fill racing a flush is discarded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (fill_i && fill_set_i == SET_W'(s) && fill_way_i == WAY_W'(w))
            valid_q[s][w] <= !(flush_i && fill_virt_i);
          else if (flush_i && virt_q[s][w])
            valid_q[s][w] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      virt_q[fill_set_i][fill_way_i] <= fill_virt_i;
      wok_q[fill_set_i][fill_way_i]  <= fill_wr_ok_i;
      asid_q[fill_set_i][fill_way_i] <= fill_asid_i;
      tag_q[fill_set_i][fill_way_i]  <= fill_tag_i;
    end
  end

  assign rd_valid_o = valid_q[rd_set_i];
  assign rd_virt_o  = virt_q[rd_set_i];
  assign rd_wok_o   = wok_q[rd_set_i];
  assign rd_asid_o  = asid_q[rd_set_i];
  assign rd_tag_o   = tag_q[rd_set_i];
endmodule

// File: rtl/ovl_way_match.sv
module ovl_way_match
  import ovl_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int ASID_W = 16,
  parameter int TAG_W  = 36,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  path_e                        path_i,
  input  logic [TAG_W-1:0]             key_tag_i,
  input  logic [ASID_W-1:0]            key_asid_i,
  input  logic                         key_ok_i,
  input  logic                         wr_i,
  input  logic [WAYS-1:0]              rd_valid_i,
  input  logic [WAYS-1:0]              rd_virt_i,
  input  logic [WAYS-1:0]              rd_wok_i,
  input  logic [WAYS-1:0][ASID_W-1:0]  rd_asid_i,
  input  logic [WAYS-1:0][TAG_W-1:0]   rd_tag_i,
  output logic                         hit_o,
  output logic                         fault_o,
  output logic [WAY_W-1:0]             way_o
);
  logic [WAYS-1:0] match, deny;
  logic            virt;

  assign virt = (path_i == PATH_VIRT);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = rd_valid_i[w] && (rd_virt_i[w] == virt) && key_ok_i &&
                      (rd_tag_i[w] == key_tag_i) &&
                      (!virt || rd_asid_i[w] == key_asid_i);
    assign deny[w]  = virt && wr_i && !rd_wok_i[w];
  end

  // lowest matching way wins
  always_comb begin
    hit_o   = 1'b0;
    fault_o = 1'b0;
    way_o   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        way_o   = WAY_W'(w);
        fault_o = deny[w];
        hit_o   = !deny[w];
      end
    end
  end
endmodule

// File: rtl/ovl_l1_lookup.sv
module ovl_l1_lookup
  import ovl_pkg::*;
#(
  parameter int VA_W       = 48,
  parameter int PA_W       = 44,
  parameter int PAGE_BYTES = 4096,
  parameter int LINE_BYTES = 64,
  parameter int WAYS       = 8,
  parameter int ASID_W     = 16,
  parameter int CNT_W      = 16,
  parameter bit USE_RANGE  = 1'b0,
  localparam int PG_W  = $clog2(PAGE_BYTES),
  localparam int LN_W  = $clog2(LINE_BYTES),
  localparam int SET_W = PG_W - LN_W,
  localparam int SETS  = 1 << SET_W,
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = VA_W - PG_W,
  localparam int PPN_W = PA_W - PG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [VA_W-1:0]   cfg_wdata_i,
  input  logic              req_i,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [ASID_W-1:0] req_asid_i,
  input  logic              req_wr_i,
  output logic              tlb_req_o,
  input  logic              tlb_valid_i,
  input  logic [PPN_W-1:0]  tlb_ppn_i,
  input  logic              fill_i,
  input  logic [SET_W-1:0]  fill_set_i,
  input  logic [WAY_W-1:0]  fill_way_i,
  input  logic              fill_virt_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic              fill_wr_ok_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic              flush_i,
  output logic              resp_valid_o,
  output logic              hit_o,
  output logic              fault_o,
  output logic [WAY_W-1:0]  way_o,
  output logic [CNT_W-1:0]  saved_o
);
  path_e              req_path, st_path;
  logic               vc_en;
  logic               st_v, st_wr;
  logic [TAG_W-1:0]   st_tag, key_tag;
  logic [SET_W-1:0]   st_set;
  logic [ASID_W-1:0]  st_asid;
  logic               key_ok, m_hit, m_fault;
  logic [WAY_W-1:0]   m_way;
  logic [CNT_W-1:0]   saved_q;

  logic [WAYS-1:0]             rd_valid, rd_virt, rd_wok;
  logic [WAYS-1:0][ASID_W-1:0] rd_asid;
  logic [WAYS-1:0][TAG_W-1:0]  rd_tag;

  ovl_mode_sel #(.VA_W(VA_W), .USE_RANGE(USE_RANGE)) u_sel (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .va_i(req_va_i), .path_o(req_path), .en_o(vc_en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_v    <= 1'b0;
      st_wr   <= 1'b0;
      st_tag  <= '0;
      st_set  <= '0;
      st_asid <= '0;
      st_path <= PATH_PHYS;
    end else begin
      st_v <= req_i;
      if (req_i) begin
        st_wr   <= req_wr_i;
        st_tag  <= req_va_i[VA_W-1:PG_W];
        st_set  <= req_va_i[PG_W-1:LN_W];
        st_asid <= req_asid_i;
        st_path <= req_path;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) saved_q <= '0;
    else if (req_i && req_path == PATH_VIRT && saved_q != '1) saved_q <= saved_q + 1'b1;
  end

  ovl_tag_store #(.SETS(SETS), .WAYS(WAYS), .ASID_W(ASID_W), .TAG_W(TAG_W)) u_store (
    .clk_i, .rst_ni, .fill_i, .fill_set_i, .fill_way_i, .fill_virt_i,
    .fill_asid_i, .fill_wr_ok_i, .fill_tag_i, .flush_i,
    .rd_set_i(st_set), .rd_valid_o(rd_valid), .rd_virt_o(rd_virt),
    .rd_wok_o(rd_wok), .rd_asid_o(rd_asid), .rd_tag_o(rd_tag)
  );

  assign key_tag = (st_path == PATH_VIRT) ? st_tag : TAG_W'(tlb_ppn_i);
  assign key_ok  = (st_path == PATH_VIRT) || tlb_valid_i;

  ovl_way_match #(.WAYS(WAYS), .ASID_W(ASID_W), .TAG_W(TAG_W)) u_match (
    .path_i(st_path), .key_tag_i(key_tag), .key_asid_i(st_asid),
    .key_ok_i(key_ok), .wr_i(st_wr), .rd_valid_i(rd_valid),
    .rd_virt_i(rd_virt), .rd_wok_i(rd_wok), .rd_asid_i(rd_asid),
    .rd_tag_i(rd_tag), .hit_o(m_hit), .fault_o(m_fault), .way_o(m_way)
  );

  assign tlb_req_o    = req_i && (req_path == PATH_PHYS);
  assign resp_valid_o = st_v;
  assign hit_o        = st_v && m_hit;
  assign fault_o      = st_v && m_fault;
  assign way_o        = (st_v && m_hit) ? m_way : '0;
  assign saved_o      = saved_q;
endmodule

// File: rtl/ovl_l1_lookup_chk.sv
module ovl_l1_lookup_chk #(
  parameter int CNT_W     = 16,
  parameter bit USE_RANGE = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             va_msb_i,
  input logic             vc_en_i,
  input logic             tlb_req_o,
  input logic             resp_valid_o,
  input logic             hit_o,
  input logic             fault_o,
  input logic [CNT_W-1:0] saved_o
);
  a_r3_virt_no_tlb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!USE_RANGE && req_i && vc_en_i && va_msb_i) |-> !tlb_req_o);

  a_r3_phys_tlb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !vc_en_i) |-> tlb_req_o);

  a_r4_resp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> resp_valid_o);

  a_r4_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !resp_valid_o);

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> (!hit_o && !fault_o));

  a_r7_hit_fault_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && fault_o));

  a_r9_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (saved_o == $past(saved_o) || saved_o == CNT_W'($past(saved_o) + 1'b1)));

  a_r9_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (saved_o == '1) |=> (saved_o == '1));

  a_r9_phys_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_req_o |=> $stable(saved_o));
endmodule

bind ovl_l1_lookup ovl_l1_lookup_chk #(.CNT_W(CNT_W), .USE_RANGE(USE_RANGE)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .va_msb_i(req_va_i[VA_W-1]),
  .vc_en_i(vc_en), .tlb_req_o(tlb_req_o), .resp_valid_o(resp_valid_o),
  .hit_o(hit_o), .fault_o(fault_o), .saved_o(saved_o)
);

// File: tb/ovl_l1_lookup_tb.sv
module ovl_l1_lookup_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 48, PA_W = 44, ASID_W = 16, CNT_W = 4;
  localparam int SETS = 64, WAYS = 8, TAG_W = 36, PPN_W = 32;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we_i = 0; logic [1:0] cfg_addr_i = 0; logic [VA_W-1:0] cfg_wdata_i = 0;
  logic req_i = 0; logic [VA_W-1:0] req_va_i = 0; logic [ASID_W-1:0] req_asid_i = 0;
  logic req_wr_i = 0, tlb_valid_i = 0; logic [PPN_W-1:0] tlb_ppn_i = 0;
  logic fill_i = 0; logic [5:0] fill_set_i = 0; logic [2:0] fill_way_i = 0;
  logic fill_virt_i = 0, fill_wr_ok_i = 0; logic [ASID_W-1:0] fill_asid_i = 0;
  logic [TAG_W-1:0] fill_tag_i = 0; logic flush_i = 0;
  logic tlb_req_o, resp_valid_o, hit_o, fault_o; logic [2:0] way_o; logic [CNT_W-1:0] saved_o;
  logic r_tlb_req, r_resp, r_hit, r_fault; logic [2:0] r_way; logic [CNT_W-1:0] r_saved;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovl_l1_lookup #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .req_i, .req_va_i,
    .req_asid_i, .req_wr_i, .tlb_req_o, .tlb_valid_i, .tlb_ppn_i, .fill_i, .fill_set_i,
    .fill_way_i, .fill_virt_i, .fill_asid_i, .fill_wr_ok_i, .fill_tag_i, .flush_i,
    .resp_valid_o, .hit_o, .fault_o, .way_o, .saved_o);

  ovl_l1_lookup #(.CNT_W(CNT_W), .USE_RANGE(1'b1)) dut_rng_i (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .req_i, .req_va_i,
    .req_asid_i, .req_wr_i, .tlb_req_o(r_tlb_req), .tlb_valid_i, .tlb_ppn_i, .fill_i,
    .fill_set_i, .fill_way_i, .fill_virt_i, .fill_asid_i, .fill_wr_ok_i, .fill_tag_i,
    .flush_i, .resp_valid_o(r_resp), .hit_o(r_hit), .fault_o(r_fault), .way_o(r_way),
    .saved_o(r_saved));

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference model state
  bit m_en; logic [VA_W-1:0] m_lo, m_hi; int m_cnt;
  bit st_v, st_wr, st_virt; logic [VA_W-1:0] st_va; logic [ASID_W-1:0] st_asid;
  bit m_v[SETS][WAYS], m_virt[SETS][WAYS], m_wok[SETS][WAYS];
  logic [ASID_W-1:0] m_asid[SETS][WAYS]; logic [TAG_W-1:0] m_tag[SETS][WAYS];

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic bit virt_bit(logic [VA_W-1:0] va);
    return m_en && va[VA_W-1];
  endfunction
  function automatic bit virt_rng(logic [VA_W-1:0] va);
    return m_en && va >= m_lo && va <= m_hi;
  endfunction

  task automatic cyc(string rq);
    bit e_hit = 0, e_fault = 0, found = 0; int e_way = 0; int s;
    #1;
    s = int'(st_va[11:6]);
    if (st_v) begin
      for (int w = 0; w < WAYS; w++) begin
        if (!found && m_v[s][w] && m_virt[s][w] == st_virt &&
            (st_virt ? (m_tag[s][w] == st_va[47:12] && m_asid[s][w] == st_asid)
                     : (tlb_valid_i && m_tag[s][w] == TAG_W'(tlb_ppn_i)))) begin
          found = 1; e_way = w;
          e_fault = st_virt && st_wr && !m_wok[s][w];
          e_hit = !e_fault;
        end
      end
    end
    chk(rq, "resp_valid", resp_valid_o, st_v);
    chk(rq, "hit", hit_o, e_hit);
    chk(rq, "fault", fault_o, e_fault);
    if (e_hit) chk(rq, "way", way_o, e_way);
    chk(rq, "tlb_req", tlb_req_o, req_i && !virt_bit(req_va_i));
    if (req_i) chk(rq, "range tlb_req", r_tlb_req, !virt_rng(req_va_i));
    chk(rq, "saved", saved_o, m_cnt);
    // advance model to the next edge
    if (req_i && virt_bit(req_va_i) && m_cnt < 15) m_cnt++;
    st_v = req_i;
    if (req_i) begin
      st_va = req_va_i; st_asid = req_asid_i; st_wr = req_wr_i; st_virt = virt_bit(req_va_i);
    end
    for (int a = 0; a < SETS; a++)
      for (int w = 0; w < WAYS; w++) begin
        if (fill_i && a == int'(fill_set_i) && w == int'(fill_way_i)) begin
          m_v[a][w] = !(flush_i && fill_virt_i); m_virt[a][w] = fill_virt_i;
          m_wok[a][w] = fill_wr_ok_i; m_asid[a][w] = fill_asid_i; m_tag[a][w] = fill_tag_i;
        end else if (flush_i && m_virt[a][w]) m_v[a][w] = 0;
      end
    if (cfg_we_i) case (cfg_addr_i)
      2'd0: m_en = cfg_wdata_i[0];
      2'd1: m_lo = cfg_wdata_i;
      2'd2: m_hi = cfg_wdata_i;
      default: ;
    endcase
    @(negedge clk);
    req_i = 0; fill_i = 0; flush_i = 0; cfg_we_i = 0; tlb_valid_i = 0; req_wr_i = 0;
  endtask

  function automatic logic [VA_W-1:0] mkva(logic [TAG_W-1:0] tag, int set);
    return {tag, 6'(set), 6'h0};
  endfunction

  task automatic do_req(string rq, logic [VA_W-1:0] va, logic [ASID_W-1:0] asid, bit wr);
    req_i = 1; req_va_i = va; req_asid_i = asid; req_wr_i = wr; cyc(rq);
  endtask
  task automatic resp(string rq, bit ok, logic [PPN_W-1:0] ppn, bit eh, bit ef, int ew);
    tlb_valid_i = ok; tlb_ppn_i = ppn; #1;
    chk(rq, "direct hit", hit_o, eh);
    chk(rq, "direct fault", fault_o, ef);
    if (eh) chk(rq, "direct way", way_o, ew);
    cyc(rq);
  endtask
  task automatic do_fill(string rq, int set, int way, bit v, logic [ASID_W-1:0] asid,
                         bit wok, logic [TAG_W-1:0] tag, bit fl);
    fill_i = 1; fill_set_i = 6'(set); fill_way_i = 3'(way); fill_virt_i = v;
    fill_asid_i = asid; fill_wr_ok_i = wok; fill_tag_i = tag; flush_i = fl; cyc(rq);
  endtask
  task automatic do_cfg(string rq, int a, logic [VA_W-1:0] d);
    cfg_we_i = 1; cfg_addr_i = 2'(a); cfg_wdata_i = d; cyc(rq);
  endtask

  localparam logic [TAG_W-1:0] VT  = 36'h8_0000_0001;
  localparam logic [TAG_W-1:0] VT2 = 36'h8_0000_0002;
  localparam logic [TAG_W-1:0] VT3 = 36'h8_0000_0003;
  localparam logic [TAG_W-1:0] PT  = 36'h0_1111_2222;

  initial begin
    m_en = 0; m_lo = 0; m_hi = 0; m_cnt = 0; st_v = 0; st_va = 0; st_wr = 0; st_virt = 0; st_asid = 0;
    for (int a = 0; a < SETS; a++) for (int w = 0; w < WAYS; w++) begin
      m_v[a][w] = 0; m_virt[a][w] = 0; m_wok[a][w] = 0; m_asid[a][w] = 0; m_tag[a][w] = 0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk("R2", "reset resp_valid", resp_valid_o, 0);
    chk("R2", "reset hit", hit_o, 0);
    chk("R2", "reset fault", fault_o, 0);
    chk("R2", "reset saved", saved_o, 0);
    rst_ni = 1;
    @(negedge clk);
    cyc("R2");
    // enable is 0 after reset: top-bit address still physical
    do_req("R1", mkva(VT, 5), 16'd7, 0);
    resp("R2", 0, 0, 0, 0, 0);
    // physical line, set 5 way 2, ppn 0xABCD
    do_fill("R5", 5, 2, 0, 16'd0, 1, 36'h0_0000_ABCD, 0);
    do_req("R3", mkva(PT, 5), 16'd9, 0);
    resp("R5", 1, 32'h0000_ABCD, 1, 0, 2);
    do_req("R5", mkva(PT, 5), 16'd3, 1);
    resp("R5", 1, 32'h0000_ABCE, 0, 0, 0);
    do_req("R5", mkva(PT, 5), 16'd3, 0);
    resp("R5", 0, 32'h0000_ABCD, 0, 0, 0);
    // enable virtual path and set bounds
    do_cfg("R1", 0, 48'h1);
    do_cfg("R10", 1, 48'h8000_0000_0000);
    do_cfg("R10", 2, 48'h8000_0000_FFFF);
    do_fill("R4", 5, 3, 1, 16'd7, 0, VT, 0);
    do_fill("R4", 5, 6, 1, 16'd7, 1, VT2, 0);
    do_req("R3", mkva(VT, 5), 16'd7, 0);
    resp("R4", 1, 32'h0, 1, 0, 3);
    do_req("R4", mkva(VT, 5), 16'd8, 0);
    resp("R4", 0, 0, 0, 0, 0);
    do_req("R7", mkva(VT, 5), 16'd7, 1);
    resp("R7", 0, 0, 0, 1, 0);
    do_req("R7", mkva(VT2, 5), 16'd7, 1);
    resp("R7", 0, 0, 1, 0, 6);
    // path bit must agree with request path
    do_fill("R8", 5, 4, 0, 16'd7, 1, 36'h8_0000_0005, 0);
    do_fill("R8", 5, 5, 1, 16'd0, 1, 36'h0_0000_0001, 0);
    do_req("R8", mkva(36'h8_0000_0005, 5), 16'd7, 0);
    resp("R8", 1, 32'h0, 0, 0, 0);
    do_req("R8", mkva(PT, 5), 16'd0, 0);
    resp("R8", 1, 32'h0000_0001, 0, 0, 0);
    do_req("R1", mkva(PT, 5), 16'd0, 0);
    resp("R1", 1, 32'h0000_ABCD, 1, 0, 2);
    // flush: virtual gone, physical kept; race with fills
    flush_i = 1; cyc("R6");
    do_req("R6", mkva(VT2, 5), 16'd7, 0);
    resp("R6", 0, 0, 0, 0, 0);
    do_req("R6", mkva(PT, 5), 16'd0, 0);
    resp("R6", 1, 32'h0000_ABCD, 1, 0, 2);
    do_fill("R6", 7, 0, 1, 16'd7, 1, VT3, 1);
    do_fill("R6", 7, 1, 0, 16'd0, 1, 36'h0_0000_0077, 1);
    do_req("R6", mkva(VT3, 7), 16'd7, 0);
    resp("R6", 0, 0, 0, 0, 0);
    do_req("R6", mkva(PT, 7), 16'd0, 0);
    resp("R6", 1, 32'h0000_0077, 1, 0, 1);
    // range classifier edges
    do_req("R10", 48'h8000_0000_0000, 16'd0, 0);
    do_req("R10", 48'h8000_0000_FFFF, 16'd0, 0);
    do_req("R10", 48'h8000_0001_0000, 16'd0, 0);
    do_req("R10", 48'h7FFF_FFFF_FFFF, 16'd0, 0);
    cyc("R10");
    // counter saturation
    for (int i = 0; i < 20; i++) do_req("R9", mkva(VT, 1), 16'd1, 0);
    cyc("R9");
    #1 chk("R9", "saturated count", saved_o, 15);
    // disable again
    do_cfg("R1", 0, 48'h0);
    do_req("R1", mkva(VT, 5), 16'd7, 0);
    cyc("R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule